// File: doc/BRIEF.md
# DRAM Bank Open-Row Sequencer

This block sits between a simple in-order request port and a multi-bank DRAM whose row and column addresses share one bus. Each request names a bank, a row, a column, a direction and (for writes) a data word. The sequencer remembers which row each bank currently holds open in its sense amplifiers. A request to that same row becomes a single column command, so a run of such requests forms a burst with no activate between its commands. A request to a bank with nothing open gets an activate and then the column command. A request to a bank holding some other row gets a precharge, an activate, and then the column command.

Within one bank, every step is held back until a programmable number of cycles has passed since the previous command to that bank. The one exception is a column command that directly follows another column command to the same bank. Read data comes back from the device a fixed number of cycles after the read command. The sequencer captures it and presents it on a one-cycle valid strobe, in request order.

The controlling state machine has five states. IDLE offers ready and latches a request. CHECK compares the latched request with the bank table. PRE waits for the bank timer and issues a precharge. ACT waits for the bank timer and issues an activate. COL issues the read or write. The transitions are:
- IDLE to CHECK when a request is taken.
- CHECK to COL on a row hit, to PRE when a different row is open, and to ACT when the bank is closed.
- PRE to ACT and ACT to COL, each once its command goes out.
- COL to IDLE once the column command goes out.

Top module: `orow_sequencer`

## Requirements
- R1: After reset, req_ready is 1, dram_cmd is NOP (0) and rsp_valid is 0. Every bank starts closed, so the first request to any bank produces an activate.
- R2: A request is taken on a cycle where req_valid and req_ready are both 1. req_ready stays 0 from then until that request's column command has been issued.
- R3: A request whose row equals the row open in its bank produces only a column command, with no activate and no precharge.
- R4: A request to a bank holding a different open row produces exactly one precharge, then one activate, then the column command.
- R5: A request to a closed bank produces one activate and then the column command, with no precharge. An activate is never issued to a bank that is open.
- R6: Two commands to the same bank are at least T_STEP cycles apart. The exception is a column command that follows a column command to that bank.
- R7: An activate drives the row on dram_addr. A column command drives the column, zero-extended, on dram_addr. Every command drives its bank on dram_bank.
- R8: A write column command (code 3) carries the request's data on dram_wdata.
- R9: Suppose a read command (code 2) is on the bus in cycle c. Then dram_rdata is sampled in cycle c+RD_LAT, and rsp_valid is 1 for one cycle in c+RD_LAT+1 with that data. Responses return in request order.
- R10: Each bank keeps its open row independently. Commands to one bank never close or change the row held by another bank.
- R11: At most one command is issued per cycle. dram_cmd codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| dram_cmd | output | 3 | Command code (R11) |
| dram_bank | output | BANK_W | Command bank |
| dram_addr | output | ADDR_W | Shared row/column address |
| dram_wdata | output | DATA_W | Write data to device |
| dram_rdata | input | DATA_W | Read data from device |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | DATA_W | Read response data |

## Verification
The assertions assume that the device really returns data RD_LAT cycles after each read. They also assume that a requester holds req_valid and the request fields steady until the request is taken. The bench drives its requests only from a task that holds them until acceptance. Its device model answers every read with exactly that latency. Random requests use few rows per bank, so hits, misses and closed-bank cases all occur often.

// File: rtl/orow_pkg.sv
package orow_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_PRE,
        ST_ACT,
        ST_COL
    } seq_state_e;
endpackage

// File: rtl/orow_bank_table.sv
module orow_bank_table
    import orow_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int ROW_W   = 12,
    parameter int T_STEP  = 4,
    localparam int BANK_W = $clog2(N_BANKS),
    localparam int TMR_W  = $clog2(T_STEP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  dram_cmd_e         upd_cmd,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [BANK_W-1:0] q_bank,
    output logic              q_open,
    output logic [ROW_W-1:0]  q_row,
    output logic              q_tmr_ok,
    output logic              q_last_col
);
    logic [N_BANKS-1:0] open_v;
    logic [N_BANKS-1:0] lastcol_v;
    logic [N_BANKS-1:0] tmr_zero_v;
    logic [ROW_W-1:0]   row_a [N_BANKS];

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        logic [TMR_W-1:0] tmr;
        logic             hit;
        assign hit = upd_en && (upd_bank == BANK_W'(g));
        assign tmr_zero_v[g] = (tmr == '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_v[g]    <= 1'b0;
                lastcol_v[g] <= 1'b0;
                row_a[g]     <= '0;
                tmr          <= '0;
            end else if (hit) begin
                tmr <= TMR_W'(T_STEP - 1);
                unique case (upd_cmd)
                    CMD_ACT: begin
                        open_v[g]    <= 1'b1;
                        row_a[g]     <= upd_row;
                        lastcol_v[g] <= 1'b0;
                    end
                    CMD_PRE: begin
                        open_v[g]    <= 1'b0;
                        lastcol_v[g] <= 1'b0;
                    end
                    CMD_RD, CMD_WR: lastcol_v[g] <= 1'b1;
                    default: ;
                endcase
            end else if (tmr != '0) begin
                tmr <= tmr - 1'b1;
            end
        end
    end

    assign q_open     = open_v[q_bank];
    assign q_row      = row_a[q_bank];
    assign q_tmr_ok   = tmr_zero_v[q_bank];
    assign q_last_col = lastcol_v[q_bank];
endmodule

// File: rtl/orow_fsm.sv
module orow_fsm
    import orow_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 8,
    parameter int DATA_W  = 16,
    localparam int BANK_W = $clog2(N_BANKS),
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [BANK_W-1:0] q_bank,
    input  logic              q_open,
    input  logic [ROW_W-1:0]  q_row,
    input  logic              q_tmr_ok,
    input  logic              q_last_col,
    output logic              iss_en,
    output dram_cmd_e         iss_cmd,
    output logic [ROW_W-1:0]  iss_row,
    output logic [2:0]        dram_cmd,
    output logic [BANK_W-1:0] dram_bank,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [DATA_W-1:0] dram_wdata
);
    seq_state_e        state, state_nx;
    logic [BANK_W-1:0] rq_bank;
    logic [ROW_W-1:0]  rq_row;
    logic [COL_W-1:0]  rq_col;
    logic              rq_we;
    logic [DATA_W-1:0] rq_wdata;

    assign req_ready = (state == ST_IDLE);
    assign q_bank    = rq_bank;
    assign iss_row   = rq_row;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_bank  <= '0;
            rq_row   <= '0;
            rq_col   <= '0;
            rq_we    <= 1'b0;
            rq_wdata <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            rq_bank  <= req_bank;
            rq_row   <= req_row;
            rq_col   <= req_col;
            rq_we    <= req_we;
            rq_wdata <= req_wdata;
        end
    end

    always_comb begin
        state_nx = state;
        iss_en   = 1'b0;
        iss_cmd  = CMD_NOP;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_CHECK;
            ST_CHECK: begin
                if (q_open && q_row == rq_row) state_nx = ST_COL;
                else if (q_open)               state_nx = ST_PRE;
                else                           state_nx = ST_ACT;
            end
            ST_PRE: if (q_tmr_ok) begin
                iss_en   = 1'b1;
                iss_cmd  = CMD_PRE;
                state_nx = ST_ACT;
            end
            ST_ACT: if (q_tmr_ok) begin
                iss_en   = 1'b1;
                iss_cmd  = CMD_ACT;
                state_nx = ST_COL;
            end
            ST_COL: if (q_tmr_ok || q_last_col) begin
                iss_en   = 1'b1;
                iss_cmd  = rq_we ? CMD_WR : CMD_RD;
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_cmd   <= CMD_NOP;
            dram_bank  <= '0;
            dram_addr  <= '0;
            dram_wdata <= '0;
        end else begin
            dram_cmd   <= iss_en ? iss_cmd : CMD_NOP;
            dram_bank  <= iss_en ? rq_bank : '0;
            dram_wdata <= (iss_en && iss_cmd == CMD_WR) ? rq_wdata : '0;
            unique case (iss_cmd)
                CMD_ACT:        dram_addr <= ADDR_W'(rq_row);
                CMD_RD, CMD_WR: dram_addr <= ADDR_W'(rq_col);
                default:        dram_addr <= '0;
            endcase
        end
    end
endmodule

// File: rtl/orow_rd_return.sv
module orow_rd_return #(
    parameter int DATA_W = 16,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issued,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [RD_LAT-1:0] pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            pend[0] <= rd_issued;
            for (int i = 1; i < RD_LAT; i++) pend[i] <= pend[i-1];
            rsp_valid <= pend[RD_LAT-1];
            if (pend[RD_LAT-1]) rsp_data <= dram_rdata;
        end
    end
endmodule

// File: rtl/orow_sequencer.sv
module orow_sequencer
    import orow_pkg::*;
#(
    parameter int N_BANKS = 4,
    parameter int ROW_W   = 12,
    parameter int COL_W   = 8,
    parameter int DATA_W  = 16,
    parameter int T_STEP  = 4,
    parameter int RD_LAT  = 2,
    localparam int BANK_W = $clog2(N_BANKS),
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [2:0]        dram_cmd,
    output logic [BANK_W-1:0] dram_bank,
    output logic [ADDR_W-1:0] dram_addr,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    logic [BANK_W-1:0] q_bank;
    logic              q_open, q_tmr_ok, q_last_col;
    logic [ROW_W-1:0]  q_row;
    logic              iss_en;
    dram_cmd_e         iss_cmd;
    logic [ROW_W-1:0]  iss_row;

    orow_bank_table #(.N_BANKS(N_BANKS), .ROW_W(ROW_W), .T_STEP(T_STEP)) u_table (
        .clk(clk), .rst_n(rst_n),
        .upd_en(iss_en), .upd_cmd(iss_cmd), .upd_bank(q_bank), .upd_row(iss_row),
        .q_bank(q_bank), .q_open(q_open), .q_row(q_row),
        .q_tmr_ok(q_tmr_ok), .q_last_col(q_last_col)
    );

    orow_fsm #(.N_BANKS(N_BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_we(req_we), .req_wdata(req_wdata),
        .q_bank(q_bank), .q_open(q_open), .q_row(q_row),
        .q_tmr_ok(q_tmr_ok), .q_last_col(q_last_col),
        .iss_en(iss_en), .iss_cmd(iss_cmd), .iss_row(iss_row),
        .dram_cmd(dram_cmd), .dram_bank(dram_bank),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata)
    );

    orow_rd_return #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .rd_issued(dram_cmd == CMD_RD), .dram_rdata(dram_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );
endmodule

// File: rtl/orow_seq_checker.sv
module orow_seq_checker #(
    parameter int N_BANKS = 4,
    parameter int T_STEP  = 4,
    parameter int BANK_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        dram_cmd,
    input logic [BANK_W-1:0] dram_bank,
    input logic              rsp_valid
);
    logic [N_BANKS-1:0] ck_open;
    logic [N_BANKS-1:0] ck_lastcol;
    logic [15:0]        ck_gap [N_BANKS];
    logic [7:0]         ck_outst;
    logic               is_col;

    assign is_col = (dram_cmd == 3'd2) || (dram_cmd == 3'd3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_open    <= '0;
            ck_lastcol <= '0;
            ck_outst   <= '0;
            for (int i = 0; i < N_BANKS; i++) ck_gap[i] <= 16'(T_STEP);
        end else begin
            for (int i = 0; i < N_BANKS; i++) begin
                if (dram_cmd != 3'd0 && dram_bank == BANK_W'(i)) begin
                    ck_gap[i]     <= 16'd1;
                    ck_lastcol[i] <= is_col;
                    if (dram_cmd == 3'd1) ck_open[i] <= 1'b1;
                    if (dram_cmd == 3'd4) ck_open[i] <= 1'b0;
                end else if (ck_gap[i] < 16'(T_STEP)) begin
                    ck_gap[i] <= ck_gap[i] + 16'd1;
                end
            end
            ck_outst <= ck_outst + ((dram_cmd == 3'd2) ? 8'd1 : 8'd0)
                                 - (rsp_valid ? 8'd1 : 8'd0);
        end
    end

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_col_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> ck_open[dram_bank]);
    assert_pre_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == 3'd4) |-> ck_open[dram_bank]);
    assert_act_needs_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd == 3'd1) |-> !ck_open[dram_bank]);
    assert_step_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dram_cmd != 3'd0 && !(is_col && ck_lastcol[dram_bank]))
            |-> ck_gap[dram_bank] >= 16'(T_STEP));
    assert_rsp_has_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ck_outst != 8'd0);
    assert_cmd_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cmd <= 3'd4);
endmodule

bind orow_sequencer orow_seq_checker #(
    .N_BANKS(N_BANKS), .T_STEP(T_STEP), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .dram_cmd(dram_cmd), .dram_bank(dram_bank), .rsp_valid(rsp_valid)
);

// File: tb/orow_sequencer_bench.sv
module orow_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4, RW = 12, CW = 8, DW = 16, TS = 4, RL = 2;
    localparam int AW = 12;

    typedef struct {
        int b; int r; int c; bit we; logic [DW-1:0] d; int act; int pre;
    } pend_t;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_we = 0;
    logic req_ready;
    logic [1:0] req_bank = 0;
    logic [RW-1:0] req_row = 0;
    logic [CW-1:0] req_col = 0;
    logic [DW-1:0] req_wdata = 0, dram_wdata, dram_rdata = 0, rsp_data;
    logic [2:0] dram_cmd;
    logic [1:0] dram_bank;
    logic [AW-1:0] dram_addr;
    logic rsp_valid;

    int total = 0, bad = 0, cyc = 0;
    logic [DW-1:0] ref_mem [NB][8][8];
    logic [DW-1:0] dev_mem [NB][8][8];
    bit  r_open [NB];
    int  r_row  [NB];
    bit  m_open [NB];
    int  m_row  [NB];
    int  m_last [NB];
    bit  m_lcol [NB];
    int  act_n = 0, pre_n = 0;
    pend_t pq[$];
    logic [DW-1:0] exp_rd[$];
    int rsp_due[$];
    int dq_due[$];
    logic [DW-1:0] dq_dat[$];

    orow_sequencer u_orow_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_we(req_we),
        .req_wdata(req_wdata), .dram_cmd(dram_cmd), .dram_bank(dram_bank),
        .dram_addr(dram_addr), .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DW-1:0] seed_word(int b, int r, int c);
        return DW'((b * 64 + r * 8 + c) ^ 16'hA5C3);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model and command monitor
    always @(negedge clk) begin
        if (rst_n) begin
            int b;
            b = int'(dram_bank);
            if (dram_cmd == 3'd1 || dram_cmd == 3'd4) begin
                chk(cyc - m_last[b] >= TS, "R6 step gap", cyc - m_last[b], TS);
                if (dram_cmd == 3'd1) begin
                    chk(!m_open[b], "R5 act to closed bank", int'(m_open[b]), 0);
                    m_open[b] = 1; m_row[b] = int'(dram_addr); act_n++;
                end else begin
                    chk(m_open[b], "R4 pre to open bank", int'(m_open[b]), 1);
                    m_open[b] = 0; pre_n++;
                end
                m_last[b] = cyc; m_lcol[b] = 0;
            end else if (dram_cmd == 3'd2 || dram_cmd == 3'd3) begin
                pend_t p;
                int c;
                c = int'(dram_addr);
                if (!m_lcol[b])
                    chk(cyc - m_last[b] >= TS, "R6 step gap", cyc - m_last[b], TS);
                chk(m_open[b], "R3 col to open bank", int'(m_open[b]), 1);
                if (pq.size() != 0) begin
                    p = pq.pop_front();
                    chk(p.act == act_n, "R3/R5 activate count", act_n, p.act);
                    chk(p.pre == pre_n, "R4 precharge count", pre_n, p.pre);
                    chk(b == p.b, "R7 bank", b, p.b);
                    chk(m_row[b] == p.r, "R7 row on activate", m_row[b], p.r);
                    chk(c == p.c, "R7 column", c, p.c);
                    chk((dram_cmd == 3'd3) == p.we, "R8 direction", int'(dram_cmd), p.we ? 3 : 2);
                    if (p.we) chk(dram_wdata == p.d, "R8 write data", int'(dram_wdata), int'(p.d));
                end else chk(0, "R2 column without request", 1, 0);
                if (dram_cmd == 3'd3) dev_mem[b][m_row[b] % 8][c % 8] = dram_wdata;
                else begin
                    dq_due.push_back(cyc + RL);
                    dq_dat.push_back(dev_mem[b][m_row[b] % 8][c % 8]);
                    rsp_due.push_back(cyc + RL + 1);
                end
                act_n = 0; pre_n = 0;
                m_last[b] = cyc; m_lcol[b] = 1;
            end
            if (rsp_valid) begin
                if (rsp_due.size() != 0 && exp_rd.size() != 0) begin
                    int due;
                    logic [DW-1:0] e;
                    due = rsp_due.pop_front();
                    e = exp_rd.pop_front();
                    chk(cyc == due, "R9 response cycle", cyc, due);
                    chk(rsp_data == e, "R9 response data", int'(rsp_data), int'(e));
                end else chk(0, "R9 unexpected response", 1, 0);
            end
            if (dq_due.size() != 0 && dq_due[0] == cyc) begin
                void'(dq_due.pop_front());
                dram_rdata = dq_dat.pop_front();
            end else dram_rdata = 'x;
        end
    end

    // called at a negedge; returns at the negedge after acceptance
    task automatic send(input int b, input int r, input int c, input bit we, input logic [DW-1:0] d);
        pend_t p;
        req_bank = 2'(b); req_row = RW'(r); req_col = CW'(c);
        req_we = we; req_wdata = d; req_valid = 1;
        while (!req_ready) @(negedge clk);
        p.b = b; p.r = r; p.c = c; p.we = we; p.d = d;
        if (!r_open[b])       begin p.act = 1; p.pre = 0; end
        else if (r_row[b] == r) begin p.act = 0; p.pre = 0; end
        else                  begin p.act = 1; p.pre = 1; end
        r_open[b] = 1; r_row[b] = r;
        pq.push_back(p);
        if (we) ref_mem[b][r][c] = d;
        else exp_rd.push_back(ref_mem[b][r][c]);
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int b = 0; b < NB; b++) begin
            r_open[b] = 0; m_open[b] = 0; m_last[b] = -1000; m_lcol[b] = 0; r_row[b] = 0;
            for (int r = 0; r < 8; r++)
                for (int c = 0; c < 8; c++) begin
                    ref_mem[b][r][c] = seed_word(b, r, c);
                    dev_mem[b][r][c] = seed_word(b, r, c);
                end
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
        chk(dram_cmd == 0, "R1 NOP after reset", int'(dram_cmd), 0);
        chk(rsp_valid == 0, "R1 no response after reset", int'(rsp_valid), 0);
        // R5 closed bank, R3 burst of hits, R8 write then read back
        send(0, 1, 2, 1, 16'h1234);
        send(0, 1, 3, 0, 0);
        send(0, 1, 2, 0, 0);
        send(0, 1, 7, 1, 16'hBEEF);
        // R10: other bank opened, bank 0 row kept open (hit expected)
        send(1, 2, 0, 0, 0);
        send(0, 1, 7, 0, 0);
        send(1, 2, 5, 1, 16'h0F0F);
        // R4: row miss in bank 0
        send(0, 3, 4, 0, 0);
        send(0, 1, 7, 0, 0);
        // random traffic
        for (int i = 0; i < 400; i++) begin
            int b, r, c;
            bit we;
            b = int'($urandom % NB);
            r = int'($urandom % 3);
            c = int'($urandom % 8);
            we = ($urandom % 3) == 0;
            send(b, r, c, we, DW'($urandom));
        end
        repeat (20) @(negedge clk);
        chk(pq.size() == 0, "R2 all requests issued", pq.size(), 0);
        chk(exp_rd.size() == 0, "R9 all reads answered", exp_rd.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule